// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block is a first-in first-out buffer for 9-bit words that carries data from a write clock domain into a read clock domain. The two clocks run freely and may be unrelated or the very same clock. The depth is a parameter (2048 words by default). Storage is an inferred memory. Write and read pointers cross between the domains as Gray code through a parameterised synchroniser chain. The read side presents the oldest word in an output register, with a ready flag, so a consumer sees data as soon as it becomes valid.

Writes need two write enables to agree. Reads need two read enables plus an output enable. The output enable also gates the data bus, which is modelled as a data vector with an enable strobe. Four status outputs are provided: input-ready (room for a word), output-ready (a word is on the output), half-full, and one shared flag that is high when the buffer is nearly empty or nearly full. The two thresholds behind the shared flag can be loaded through the data inputs after reset and before the first write. While they are loaded, the first write enable acts as a tenth data bit.

Top module: `dcfifo_flagged`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge exactly when `wen_a`, `wen_b`, `prog_n` and `in_rdy` are all high. `in_rdy` falls on the edge that stores the DEPTH-th unread word, and no write is taken while it is low.
- R2: The word on `dout` is consumed on a rising `rd_clk` edge exactly when `ren_a`, `ren_b`, `oe` and `out_rdy` are all high. Nothing is consumed while any of them is low.
- R3: With both clocks coincident, a word written into an empty FIFO at edge n appears on `dout` and raises `out_rdy` on edge n+3.
- R4: While `out_rdy` is low, the output register keeps the last word that was read. `dout_en` equals `oe`, and `dout` reads 0 whenever `oe` is low.
- R5: While `rst_n` is low, `in_rdy`, `out_rdy` and `half_full` are low, `almost_fe` is high and the output register is 0. Reset must be held for at least four edges of each clock. `in_rdy` rises on the second `wr_clk` edge after `rst_n` goes high.
- R6: `half_full` is high when the occupancy is DEPTH/2 or more words.
- R7: `almost_fe` is high when the occupancy is at most the low offset, or at least DEPTH minus the high offset. Both offsets reset to DEPTH/8.
- R8: After reset and before any word is written, each rising `wr_clk` edge with `prog_n` low (and `in_rdy` high) loads an offset from `{wen_a, din}`, with `wen_a` as the most significant bit (bit 9). The first such edge loads the low offset and the second loads the high offset. Later such edges, and any such edge after the first write, change nothing. No word is stored while `prog_n` is low.
- R9: The occupancy behind `in_rdy`, `half_full` and `almost_fe` is counted on the write clock, and it includes the word held on the output. A write changes the three flags on the edge that stores it. With coincident clocks, a read at edge n is reflected on edge n+3. Words leave in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| din | input | 9 | Write data, also offset bits 8..0 while programming |
| wen_a | input | 1 | First write enable, also offset bit 9 while programming |
| wen_b | input | 1 | Second write enable |
| prog_n | input | 1 | Active-low offset load strobe |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| oe | input | 1 | Output enable, gates reads and the data bus |
| dout | output | 9 | Read data, 0 while `oe` is low |
| dout_en | output | 1 | High when `dout` is driven |
| in_rdy | output | 1 | Room for at least one word |
| out_rdy | output | 1 | A valid word is on the output |
| half_full | output | 1 | Occupancy at or above half the depth |
| almost_fe | output | 1 | Occupancy inside either programmed margin |

## Verification
Some properties are checked on every edge in either domain. No write pointer moves while input-ready is low, and no consumed pointer moves while output-ready is low. The output register holds its word across idle empty cycles. Half-full and the shared flag are both high when the buffer turns full. A rising output-ready always has an unread word behind it, and reset forces the flags to their idle values. Other behaviour only a bench scenario can show: the exact three-edge first-word latency, the second-edge rise of input-ready, each flag threshold, the order in which offsets load, that offset loads are ignored after a write, and that word order survives a full fill and drain.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

   // word width on both ports
   localparam int DATA_W    = 9;
   // offset source width: data pins plus the borrowed write-enable bit
   localparam int OFS_SRC_W = DATA_W + 1;

   // offset loading sequence
   typedef enum logic [1:0] {
      PRG_AE   = 2'd0,
      PRG_AF   = 2'd1,
      PRG_DONE = 2'd2
   } prog_st_e;

endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
   parameter int W      = 12,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
   parameter int W     = 9,
   parameter int DEPTH = 2048,
   parameter int AW    = 11
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/dcfifo_wr_ctl.sv
module dcfifo_wr_ctl
   import dcfifo_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int AW      = 11,
   parameter int OW      = 10,
   parameter int AE_INIT = 256,
   parameter int AF_INIT = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wen_a,
   input  logic              wen_b,
   input  logic              prog_n,
   input  logic [DATA_W-1:0] din,
   input  logic [AW:0]       rgray_s,
   output logic              wr_go,
   output logic [AW-1:0]     waddr,
   output logic [AW:0]       wgray,
   output logic              in_rdy,
   output logic              half_full,
   output logic              almost_fe
);

   localparam int PW = AW + 1;
   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

   logic [1:0]           live_q;
   logic                 live;
   logic [PW-1:0]        wptr_q;
   logic [PW-1:0]        wptr_d;
   logic [PW-1:0]        rptr_b;
   logic [PW-1:0]        cnt_d;
   logic                 full_q;
   logic                 wrote_q;
   prog_st_e             pst_q;
   logic                 prog_go;
   logic [OFS_SRC_W-1:0] ofs_src;
   logic [OW-1:0]        ofs_new;
   logic [OW-1:0]        ofs_ae_q;
   logic [OW-1:0]        ofs_af_q;

   function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   // local release of reset: two edges after rst_n rises
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 2'b00;
      else        live_q <= {live_q[0], 1'b1};
   end
   assign live = live_q[1];

   assign in_rdy = live & ~full_q;
   assign wr_go  = in_rdy & wen_a & wen_b & prog_n;
   assign wptr_d = wptr_q + PW'(wr_go);
   assign rptr_b = gray_to_bin(rgray_s);
   assign cnt_d  = wptr_d - rptr_b;
   assign waddr  = wptr_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q    <= '0;
         wgray     <= '0;
         full_q    <= 1'b0;
         half_full <= 1'b0;
         almost_fe <= 1'b1;
      end else begin
         wptr_q    <= wptr_d;
         wgray     <= wptr_d ^ (wptr_d >> 1);
         full_q    <= (cnt_d == FULL_CNT);
         half_full <= (cnt_d >= HALF_CNT);
         almost_fe <= (cnt_d <= PW'(ofs_ae_q)) ||
                      (cnt_d >= (FULL_CNT - PW'(ofs_af_q)));
      end
   end

   // offset source: the borrowed enable is the top bit
   assign ofs_src = {wen_a, din};

   if (OW == OFS_SRC_W) begin : g_ofs_full
      assign ofs_new = ofs_src;
   end else begin : g_ofs_trunc
      assign ofs_new = ofs_src[OW-1:0];
   end

   assign prog_go = live & ~prog_n & ~wrote_q & (pst_q != PRG_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wrote_q  <= 1'b0;
         pst_q    <= PRG_AE;
         ofs_ae_q <= OW'(AE_INIT);
         ofs_af_q <= OW'(AF_INIT);
      end else begin
         if (wr_go) wrote_q <= 1'b1;
         if (prog_go) begin
            if (pst_q == PRG_AE) begin
               ofs_ae_q <= ofs_new;
               pst_q    <= PRG_AF;
            end else begin
               ofs_af_q <= ofs_new;
               pst_q    <= PRG_DONE;
            end
         end
      end
   end

endmodule

// File: rtl/dcfifo_rd_ctl.sv
module dcfifo_rd_ctl
   import dcfifo_pkg::*;
#(
   parameter int AW = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_a,
   input  logic              ren_b,
   input  logic              oe,
   input  logic [AW:0]       wgray_s,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [AW-1:0]     raddr,
   output logic [AW:0]       dgray,
   output logic [DATA_W-1:0] rdq,
   output logic              out_rdy
);

   localparam int PW = AW + 1;

   logic [1:0]    live_q;
   logic          live;
   logic [PW-1:0] fptr_q;
   logic [PW-1:0] dptr_q;
   logic [PW-1:0] dptr_d;
   logic [PW-1:0] wptr_b;
   logic          has_word;
   logic          rd_go;
   logic          load;

   function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 2'b00;
      else        live_q <= {live_q[0], 1'b1};
   end
   assign live = live_q[1];

   assign wptr_b   = gray_to_bin(wgray_s);
   assign has_word = (fptr_q != wptr_b);
   assign rd_go    = out_rdy & ren_a & ren_b & oe;
   assign load     = live & has_word & (~out_rdy | rd_go);
   assign dptr_d   = dptr_q + PW'(rd_go);
   assign raddr    = fptr_q[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fptr_q  <= '0;
         dptr_q  <= '0;
         dgray   <= '0;
         rdq     <= '0;
         out_rdy <= 1'b0;
      end else begin
         fptr_q <= fptr_q + PW'(load);
         dptr_q <= dptr_d;
         dgray  <= dptr_d ^ (dptr_d >> 1);
         if (load) begin
            rdq     <= ram_rdata;
            out_rdy <= 1'b1;
         end else if (rd_go) begin
            out_rdy <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dcfifo_flagged.sv
module dcfifo_flagged
   import dcfifo_pkg::*;
#(
   parameter int DEPTH       = 2048,
   parameter int SYNC_STAGES = 2,
   parameter int AE_DEFAULT  = DEPTH / 8,
   parameter int AF_DEFAULT  = DEPTH / 8
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              wen_a,
   input  logic              wen_b,
   input  logic              prog_n,
   input  logic              ren_a,
   input  logic              ren_b,
   input  logic              oe,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en,
   output logic              in_rdy,
   output logic              out_rdy,
   output logic              half_full,
   output logic              almost_fe
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam int OW = AW - 1;

   // elaboration-time parameter checks
   if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (OW > OFS_SRC_W) begin : g_bad_ofs
      $error("offset width exceeds the pins that load it");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (AE_DEFAULT >= (1 << OW) || AF_DEFAULT >= (1 << OW)) begin : g_bad_dflt
      $error("default offsets do not fit the offset width");
   end

   logic              wr_go;
   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr;
   logic [PW-1:0]     wgray;
   logic [PW-1:0]     wgray_s;
   logic [PW-1:0]     dgray;
   logic [PW-1:0]     dgray_s;
   logic [DATA_W-1:0] ram_rdata;
   logic [DATA_W-1:0] rdq;

   dcfifo_wr_ctl #(
      .DEPTH   (DEPTH),
      .AW      (AW),
      .OW      (OW),
      .AE_INIT (AE_DEFAULT),
      .AF_INIT (AF_DEFAULT)
   ) i_wr_ctl (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .wen_a     (wen_a),
      .wen_b     (wen_b),
      .prog_n    (prog_n),
      .din       (din),
      .rgray_s   (dgray_s),
      .wr_go     (wr_go),
      .waddr     (waddr),
      .wgray     (wgray),
      .in_rdy    (in_rdy),
      .half_full (half_full),
      .almost_fe (almost_fe)
   );

   dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_w2r (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .d     (wgray),
      .q     (wgray_s)
   );

   dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_sync_r2w (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .d     (dgray),
      .q     (dgray_s)
   );

   dcfifo_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) i_ram (
      .wclk  (wr_clk),
      .we    (wr_go),
      .waddr (waddr),
      .wdata (din),
      .raddr (raddr),
      .rdata (ram_rdata)
   );

   dcfifo_rd_ctl #(.AW(AW)) i_rd_ctl (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .ren_a     (ren_a),
      .ren_b     (ren_b),
      .oe        (oe),
      .wgray_s   (wgray_s),
      .ram_rdata (ram_rdata),
      .raddr     (raddr),
      .dgray     (dgray),
      .rdq       (rdq),
      .out_rdy   (out_rdy)
   );

   assign dout_en = oe;
   assign dout    = oe ? rdq : '0;

endmodule

// File: rtl/dcfifo_chk.sv
module dcfifo_chk #(
   parameter int PW = 12,
   parameter int DW = 9
) (
   input logic          wr_clk,
   input logic          rd_clk,
   input logic          rst_n,
   input logic          in_rdy,
   input logic          out_rdy,
   input logic          half_full,
   input logic          almost_fe,
   input logic [PW-1:0] wgray,
   input logic [PW-1:0] dgray,
   input logic [DW-1:0] rdq
);

   // R1
   no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !in_rdy |=> $stable(wgray));

   // R2
   no_read_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !out_rdy |=> $stable(dgray));

   // R4
   hold_last_word_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (!out_rdy && !$past(out_rdy)) |-> $stable(rdq));

   // R6
   full_sets_flags_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (!in_rdy && $past(in_rdy)) |-> (half_full && almost_fe));

   // R3
   ready_has_data_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $rose(out_rdy) |-> (wgray != dgray));

   // R5
   always @(posedge wr_clk) begin
      if (!rst_n) begin
         reset_state_chk: assert (!in_rdy && !out_rdy && !half_full && almost_fe && rdq == '0)
            else $error("reset state violated");
      end
   end

endmodule

bind dcfifo_flagged dcfifo_chk #(
   .PW (PW),
   .DW (dcfifo_pkg::DATA_W)
) i_chk (
   .wr_clk    (wr_clk),
   .rd_clk    (rd_clk),
   .rst_n     (rst_n),
   .in_rdy    (in_rdy),
   .out_rdy   (out_rdy),
   .half_full (half_full),
   .almost_fe (almost_fe),
   .wgray     (wgray),
   .dgray     (dgray),
   .rdq       (rdq)
);

// File: tb/test_dcfifo_flagged.sv
module test_dcfifo_flagged;

   localparam int DEPTH = 2048;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n  = 1'b1;
   logic [8:0] din    = '0;
   logic       wen_a  = 1'b0;
   logic       wen_b  = 1'b0;
   logic       prog_n = 1'b1;
   logic       ren_a  = 1'b0;
   logic       ren_b  = 1'b0;
   logic       oe     = 1'b0;
   logic [8:0] dout;
   logic       dout_en, in_rdy, out_rdy, half_full, almost_fe;

   dcfifo_flagged #(.DEPTH(DEPTH)) i_dcfifo_flagged (
      .wr_clk    (clk),
      .rd_clk    (clk),
      .rst_n     (rst_n),
      .din       (din),
      .wen_a     (wen_a),
      .wen_b     (wen_b),
      .prog_n    (prog_n),
      .ren_a     (ren_a),
      .ren_b     (ren_b),
      .oe        (oe),
      .dout      (dout),
      .dout_en   (dout_en),
      .in_rdy    (in_rdy),
      .out_rdy   (out_rdy),
      .half_full (half_full),
      .almost_fe (almost_fe)
   );

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   // behavioural reference state
   int wl, rl, m_w, m_r, wh1, wh2, wh3, rh1, rh2, rh3, fet, m_x, m_y, prg, cnt, m_dq;
   bit m_wrote, m_full, m_hf, m_afe, m_ordy, wf, pf, rf;
   int memq[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         wl = 0; rl = 0; m_w = 0; m_r = 0;
         wh1 = 0; wh2 = 0; wh3 = 0; rh1 = 0; rh2 = 0; rh3 = 0;
         fet = 0; m_x = DEPTH / 8; m_y = DEPTH / 8; prg = 0; m_dq = 0;
         m_wrote = 0; m_full = 0; m_hf = 0; m_afe = 1; m_ordy = 0;
         memq.delete();
      end else begin
         wf = (wl >= 2) && !m_full && wen_a && wen_b && prog_n;
         pf = (wl >= 2) && !prog_n && !m_wrote && (prg < 2);
         rf = m_ordy && ren_a && ren_b && oe;
         // read side output stage, sees writes from three edges back
         if ((rl >= 2) && (fet < wh3) && (!m_ordy || rf)) begin
            m_dq = memq[fet];
            fet++;
            m_ordy = 1;
         end else if (rf) begin
            m_ordy = 0;
         end
         if (wf) begin
            memq.push_back(int'(din));
            m_w++;
            m_wrote = 1;
         end
         if (rf) m_r++;
         // write side flags, sees reads from three edges back
         cnt    = m_w - rh3;
         m_full = (cnt == DEPTH);
         m_hf   = (cnt >= DEPTH / 2);
         m_afe  = (cnt <= m_x) || (cnt >= DEPTH - m_y);
         if (pf) begin
            if (prg == 0) m_x = int'({wen_a, din});
            else          m_y = int'({wen_a, din});
            prg++;
         end
         wh3 = wh2; wh2 = wh1; wh1 = m_w;
         rh3 = rh2; rh2 = rh1; rh1 = m_r;
         if (wl < 2) wl++;
         if (rl < 2) rl++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // compare with the model every cycle, away from the clock edge
   always @(negedge clk) begin
      #2;
      if (!done) begin
         if (!rst_n) begin
            chk("R5 in_rdy in reset", int'(in_rdy), 0);
            chk("R5 out_rdy in reset", int'(out_rdy), 0);
            chk("R5 half_full in reset", int'(half_full), 0);
            chk("R5 almost_fe in reset", int'(almost_fe), 1);
            chk("R5 dout in reset", int'(dout), 0);
         end else begin
            chk("R1 R5 in_rdy", int'(in_rdy), int'((wl >= 2) && !m_full));
            chk("R2 R3 out_rdy", int'(out_rdy), int'(m_ordy));
            chk("R4 R9 dout", int'(dout), oe ? m_dq : 0);
            chk("R6 half_full", int'(half_full), int'(m_hf));
            chk("R7 R8 almost_fe", int'(almost_fe), int'(m_afe));
         end
         chk("R4 dout_en", int'(dout_en), int'(oe));
      end
   end

   int wd = 0;

   task automatic step(input logic wa, input logic wb, input logic pn,
                       input logic ra, input logic rb, input logic o);
      wen_a  = wa;
      wen_b  = wb;
      prog_n = pn;
      ren_a  = ra;
      ren_b  = rb;
      oe     = o;
      if (wa && wb && pn) begin
         din = 9'(wd);
         wd++;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n, input logic o);
      for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, o);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   endtask

   initial begin
      #1 rst_n = 1'b0;
      @(negedge clk);
      // R5: reset held for six edges of the shared clock
      idle(6, 1);
      rst_n = 1'b1;
      idle(4, 1);

      // R8: low offset 3, high offset {1, 9'h00A} = 522 through the borrowed bit
      din = 9'd3;   step(0, 0, 0, 0, 0, 1);
      din = 9'h00A; step(1, 0, 0, 0, 0, 1);
      din = 9'd77;  step(1, 1, 0, 0, 0, 1); // third load ignored, no write
      idle(3, 1);

      // R3: single word, then blocked reads (R2), then a real read
      step(1, 1, 1, 0, 0, 1);
      idle(6, 1);
      step(0, 0, 1, 1, 0, 1);
      step(0, 0, 1, 0, 1, 1);
      step(0, 0, 1, 1, 1, 0);
      step(0, 0, 1, 1, 1, 1);
      idle(5, 1);                // R4: last word held
      idle(2, 0);

      // R8: offset load after the first write is ignored
      din = 9'd100; step(0, 0, 0, 0, 0, 1);
      din = 9'd200; step(0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 5; i++) step(1, 1, 1, 0, 0, 1);
      idle(8, 1);

      // R1 R6 R7: fill past full, writes beyond the depth are refused
      for (int i = 0; i < DEPTH + 10; i++) step(1, 1, 1, 0, 0, 1);
      idle(6, 1);
      // R9: drain in order, with output enable dropping now and then
      for (int i = 0; i < DEPTH + 20; i++)
         step(0, 0, 1, 1, 1, (i % 7) != 3);
      idle(6, 1);

      // mixed streaming
      for (int i = 0; i < 600; i++)
         step((i % 3) != 0, 1, 1, (i % 4) != 3, 1, 1);
      idle(10, 1);

      // R5 R7: second reset restores the default offsets
      rst_n = 1'b0;
      idle(6, 1);
      rst_n = 1'b1;
      idle(3, 1);
      for (int i = 0; i < 300; i++) step(1, 1, 1, 0, 0, 1);
      idle(6, 1);
      for (int i = 0; i < 320; i++) step(0, 0, 1, (i % 2) == 0, 1, 1);
      idle(10, 1);

      finish_run();
   end

   initial begin
      #(8 * 200000);
      nfail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
   end

endmodule